// File: doc/BRIEF.md
# Machine-Mode Trap Controller with Control and Status Registers

This block handles machine-mode trap entry and trap return for a 32-bit integer core, and it holds the five control and status registers that these events touch: mstatus, mie, mtvec, mepc and mcause. Each cycle it inspects the instruction that is being decoded and the two interrupt request lines. When it sees ecall, ebreak or mret, or an interrupt that is enabled, it asserts a redirect request in that same cycle and supplies the target address. All of the register updates for that event take effect at the clock edge that ends the cycle.

When no trap or return is taken, the block executes the register-access instructions (read-and-write, read-and-set, read-and-clear) that the decoded instruction names. It returns the old register value combinationally. The core supplies the source operand, which is either a register value or an immediate. Trap-side updates go through an internal direct-write path. That path has priority over an instruction write in the same cycle.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset, mstatus, mie, mepc and mcause read as 0 and mtvec reads as the MTVEC_RST parameter (default 0).
- R2: A register instruction (opcode 0x73, funct3 low bits 01 write, 10 set, 11 clear, csr address in bits 31:20) returns the old value on csr_rdata_o in the same cycle. From the next cycle the register holds src, old|src or old&~src respectively.
- R3: In mie only bit 7 (timer enable) and bit 11 (external enable) can be written. In mstatus only bits 3 (MIE), 7 (MPIE) and 12:11 (MPP) can be written. Addresses other than 0x300, 0x304, 0x305, 0x341 and 0x342 read as 0 and ignore writes.
- R4: ecall (0x00000073) asserts redirect_o in the same cycle with redirect_addr_o = mtvec with bits 1:0 cleared. Afterwards mcause = 11 and mepc = pc_i.
- R5: ebreak (0x00100073) behaves as in R4 but with mcause = 3.
- R6: On trap entry, MPIE takes the old MIE value, MIE becomes 0 and MPP becomes 0b11, all at the same edge as the mepc and mcause updates.
- R7: An interrupt is taken only while MIE = 1 and the matching mie bit is set. irq_i bit 0 is the timer request and gives mcause 0x80000007. irq_i bit 1 is the external request and gives mcause 0x8000000B. External wins when both are pending.
- R8: When jump_i is high in the cycle of a trap entry, mepc receives jump_addr_i instead of pc_i.
- R9: mret (0x30200073) asserts redirect_o with redirect_addr_o = mepc. Afterwards MIE equals the old MPIE and MPIE = 1.
- R10: In a cycle where a trap or return is taken, a register-instruction write present on instr_i is discarded. This includes writes to registers that the trap itself leaves alone.
- R11: An enabled interrupt takes priority over ecall or ebreak in the same cycle, and the recorded cause is the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction in the decode stage |
| pc_i | input | 32 | Address of that instruction |
| jump_i | input | 1 | A jump is resolving this cycle |
| jump_addr_i | input | 32 | Target of the resolving jump |
| irq_i | input | 2 | Interrupt requests: bit 0 timer, bit 1 external |
| csr_src_i | input | 32 | Source operand of a register instruction |
| redirect_o | output | 1 | Request to load the PC with redirect_addr_o |
| redirect_addr_o | output | 32 | Handler address on entry, mepc on return |
| csr_rdata_o | output | 32 | Old value of the addressed register |

## Verification
The hardest case to reach is an interrupt that arrives while a register-write instruction sits in decode. There the direct-write path and the instruction write compete for the same edge. The stimulus first programs mtvec and the enables through ordinary instructions. It then raises the timer request in the same cycle as a write to mtvec, and it reads mtvec back to confirm that the write was dropped. A similar pairing of an interrupt with ecall exercises the cause priority. Trap entries with a jump in flight exercise the choice of mepc source.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
   typedef enum logic [1:0] {
      CSR_NONE,
      CSR_WRITE,
      CSR_SET,
      CSR_CLEAR
   } csr_op_e;

   localparam logic [11:0] A_MSTATUS = 12'h300;
   localparam logic [11:0] A_MIE     = 12'h304;
   localparam logic [11:0] A_MTVEC   = 12'h305;
   localparam logic [11:0] A_MEPC    = 12'h341;
   localparam logic [11:0] A_MCAUSE  = 12'h342;

   localparam int ST_MIE    = 3;
   localparam int ST_MPIE   = 7;
   localparam int ST_MPP_LO = 11;

   localparam int IE_TIMER = 7;
   localparam int IE_EXT   = 11;

   localparam logic [3:0] CAUSE_BREAK  = 4'd3;
   localparam logic [3:0] CAUSE_ECALL  = 4'd11;
   localparam logic [3:0] CAUSE_TIMER  = 4'd7;
   localparam logic [3:0] CAUSE_EXT    = 4'd11;

   localparam logic [6:0] OPC_SYSTEM = 7'h73;
endpackage

// File: rtl/mtrap_decode.sv
module mtrap_decode
   import mtrap_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] instr_i,
   output logic            ecall_o,
   output logic            ebreak_o,
   output logic            mret_o,
   output csr_op_e         op_o,
   output logic [11:0]     addr_o
);
   logic       sys;
   logic       priv;
   logic [2:0] f3;
   logic [11:0] fn12;

   assign f3     = instr_i[14:12];
   assign fn12   = instr_i[31:20];
   assign sys    = (instr_i[6:0] == OPC_SYSTEM);
   assign priv   = sys && (f3 == 3'b000) && (instr_i[19:7] == 13'd0);
   assign ecall_o  = priv && (fn12 == 12'h000);
   assign ebreak_o = priv && (fn12 == 12'h001);
   assign mret_o   = priv && (fn12 == 12'h302);
   assign addr_o   = fn12;

   always_comb begin
      op_o = CSR_NONE;
      if (sys) begin
         unique case (f3[1:0])
            2'b01:   op_o = CSR_WRITE;
            2'b10:   op_o = CSR_SET;
            2'b11:   op_o = CSR_CLEAR;
            default: op_o = CSR_NONE;
         endcase
      end
   end
endmodule

// File: rtl/mtrap_seq.sv
module mtrap_seq
   import mtrap_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit EXT_FIRST = 1'b1
) (
   input  logic            ecall_i,
   input  logic            ebreak_i,
   input  logic            mret_i,
   input  logic [1:0]      irq_i,
   input  logic [XLEN-1:0] mstatus_i,
   input  logic [XLEN-1:0] mie_i,
   input  logic [XLEN-1:0] mtvec_i,
   input  logic [XLEN-1:0] mepc_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            jump_i,
   input  logic [XLEN-1:0] jump_addr_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_addr_o,
   output logic            dw_en_o,
   output logic            dw_entry_o,
   output logic [XLEN-1:0] dw_mstatus_o,
   output logic [XLEN-1:0] dw_mepc_o,
   output logic [XLEN-1:0] dw_mcause_o
);
   logic pend_t, pend_e, irq_take, pick_ext, entry, ret;

   assign pend_t   = irq_i[0] & mie_i[IE_TIMER];
   assign pend_e   = irq_i[1] & mie_i[IE_EXT];
   assign irq_take = mstatus_i[ST_MIE] & (pend_t | pend_e);

   generate
      if (EXT_FIRST) begin : g_ext_first
         assign pick_ext = pend_e;
      end else begin : g_timer_first
         assign pick_ext = pend_e & ~pend_t;
      end
   endgenerate

   assign entry = irq_take | ecall_i | ebreak_i;
   assign ret   = mret_i & ~entry;

   always_comb begin
      dw_mcause_o = '0;
      dw_mcause_o[XLEN-1] = irq_take;
      if (irq_take)
         dw_mcause_o[3:0] = pick_ext ? CAUSE_EXT : CAUSE_TIMER;
      else
         dw_mcause_o[3:0] = ebreak_i ? CAUSE_BREAK : CAUSE_ECALL;
   end

   always_comb begin
      dw_mstatus_o = mstatus_i;
      if (entry) begin
         dw_mstatus_o[ST_MPIE]          = mstatus_i[ST_MIE];
         dw_mstatus_o[ST_MIE]           = 1'b0;
         dw_mstatus_o[ST_MPP_LO +: 2]   = 2'b11;
      end else if (ret) begin
         dw_mstatus_o[ST_MIE]  = mstatus_i[ST_MPIE];
         dw_mstatus_o[ST_MPIE] = 1'b1;
      end
   end

   assign dw_mepc_o       = jump_i ? jump_addr_i : pc_i;
   assign dw_en_o         = entry | ret;
   assign dw_entry_o      = entry;
   assign redirect_o      = entry | ret;
   assign redirect_addr_o = entry ? {mtvec_i[XLEN-1:2], 2'b00} : mepc_i;
endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
   import mtrap_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] MTVEC_RST = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  csr_op_e         op_i,
   input  logic [11:0]     addr_i,
   input  logic [XLEN-1:0] src_i,
   input  logic            dw_en_i,
   input  logic            dw_entry_i,
   input  logic [XLEN-1:0] dw_mstatus_i,
   input  logic [XLEN-1:0] dw_mepc_i,
   input  logic [XLEN-1:0] dw_mcause_i,
   output logic [XLEN-1:0] rdata_o,
   output logic [XLEN-1:0] mstatus_o,
   output logic [XLEN-1:0] mie_o,
   output logic [XLEN-1:0] mtvec_o,
   output logic [XLEN-1:0] mepc_o,
   output logic [XLEN-1:0] mcause_o
);
   localparam logic [XLEN-1:0] MSTATUS_MASK =
      (XLEN'(1) << ST_MIE) | (XLEN'(1) << ST_MPIE) | (XLEN'(3) << ST_MPP_LO);
   localparam logic [XLEN-1:0] MIE_MASK =
      (XLEN'(1) << IE_TIMER) | (XLEN'(1) << IE_EXT);

   logic [XLEN-1:0] mstatus_q, mie_q, mtvec_q, mepc_q, mcause_q;
   logic [XLEN-1:0] old_val, new_val;
   logic            hit, ins_we;

   always_comb begin
      hit     = 1'b1;
      old_val = '0;
      unique case (addr_i)
         A_MSTATUS: old_val = mstatus_q;
         A_MIE:     old_val = mie_q;
         A_MTVEC:   old_val = mtvec_q;
         A_MEPC:    old_val = mepc_q;
         A_MCAUSE:  old_val = mcause_q;
         default:   hit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (op_i)
         CSR_WRITE: new_val = src_i;
         CSR_SET:   new_val = old_val | src_i;
         CSR_CLEAR: new_val = old_val & ~src_i;
         default:   new_val = old_val;
      endcase
   end

   assign ins_we  = (op_i != CSR_NONE) && hit && !dw_en_i;
   assign rdata_o = (op_i != CSR_NONE) ? old_val : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mstatus_q <= '0;
         mie_q     <= '0;
         mtvec_q   <= MTVEC_RST;
         mepc_q    <= '0;
         mcause_q  <= '0;
      end else if (dw_en_i) begin
         mstatus_q <= dw_mstatus_i & MSTATUS_MASK;
         if (dw_entry_i) begin
            mepc_q   <= dw_mepc_i;
            mcause_q <= dw_mcause_i;
         end
      end else if (ins_we) begin
         unique case (addr_i)
            A_MSTATUS: mstatus_q <= new_val & MSTATUS_MASK;
            A_MIE:     mie_q     <= new_val & MIE_MASK;
            A_MTVEC:   mtvec_q   <= new_val;
            A_MEPC:    mepc_q    <= new_val;
            A_MCAUSE:  mcause_q  <= new_val;
            default:   ;
         endcase
      end
   end

   assign mstatus_o = mstatus_q;
   assign mie_o     = mie_q;
   assign mtvec_o   = mtvec_q;
   assign mepc_o    = mepc_q;
   assign mcause_o  = mcause_q;
endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
   import mtrap_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] MTVEC_RST = '0,
   parameter bit              EXT_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] instr_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            jump_i,
   input  logic [XLEN-1:0] jump_addr_i,
   input  logic [1:0]      irq_i,
   input  logic [XLEN-1:0] csr_src_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_addr_o,
   output logic [XLEN-1:0] csr_rdata_o
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mtrap_ctrl: XLEN must be 32");
      end
   endgenerate

   logic            is_ecall, is_ebreak, is_mret;
   csr_op_e         op;
   logic [11:0]     caddr;
   logic            dw_en, dw_entry;
   logic [XLEN-1:0] dw_mstatus, dw_mepc, dw_mcause;
   logic [XLEN-1:0] mstatus_q, mie_q, mtvec_q, mepc_q, mcause_q;

   mtrap_decode #(.XLEN(XLEN)) u_dec (
      .instr_i (instr_i),
      .ecall_o (is_ecall),
      .ebreak_o(is_ebreak),
      .mret_o  (is_mret),
      .op_o    (op),
      .addr_o  (caddr)
   );

   mtrap_seq #(.XLEN(XLEN), .EXT_FIRST(EXT_FIRST)) u_seq (
      .ecall_i        (is_ecall),
      .ebreak_i       (is_ebreak),
      .mret_i         (is_mret),
      .irq_i          (irq_i),
      .mstatus_i      (mstatus_q),
      .mie_i          (mie_q),
      .mtvec_i        (mtvec_q),
      .mepc_i         (mepc_q),
      .pc_i           (pc_i),
      .jump_i         (jump_i),
      .jump_addr_i    (jump_addr_i),
      .redirect_o     (redirect_o),
      .redirect_addr_o(redirect_addr_o),
      .dw_en_o        (dw_en),
      .dw_entry_o     (dw_entry),
      .dw_mstatus_o   (dw_mstatus),
      .dw_mepc_o      (dw_mepc),
      .dw_mcause_o    (dw_mcause)
   );

   mtrap_csr_file #(.XLEN(XLEN), .MTVEC_RST(MTVEC_RST)) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op),
      .addr_i      (caddr),
      .src_i       (csr_src_i),
      .dw_en_i     (dw_en),
      .dw_entry_i  (dw_entry),
      .dw_mstatus_i(dw_mstatus),
      .dw_mepc_i   (dw_mepc),
      .dw_mcause_i (dw_mcause),
      .rdata_o     (csr_rdata_o),
      .mstatus_o   (mstatus_q),
      .mie_o       (mie_q),
      .mtvec_o     (mtvec_q),
      .mepc_o      (mepc_q),
      .mcause_o    (mcause_q)
   );
endmodule

// File: rtl/mtrap_ctrl_chk.sv
module mtrap_ctrl_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] instr_i,
   input logic            jump_i,
   input logic [XLEN-1:0] jump_addr_i,
   input logic            redirect_o,
   input logic [XLEN-1:0] mstatus_q,
   input logic [XLEN-1:0] mie_q,
   input logic [XLEN-1:0] mepc_q
);
   logic c_mret, c_sys_evt;
   assign c_mret    = (instr_i == 32'h30200073);
   assign c_sys_evt = c_mret || (instr_i == 32'h00000073) || (instr_i == 32'h00100073);

   // R6: entry clears MIE and forces MPP to machine
   a_r6_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !c_mret) |=> (!mstatus_q[3] && mstatus_q[12:11] == 2'b11));

   // R7: nothing redirects while globally disabled unless an instruction asks
   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!mstatus_q[3] && !c_sys_evt) |-> !redirect_o);

   // R8: jump target captured as return address
   a_r8_epc_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !c_mret && jump_i) |=> (mepc_q == $past(jump_addr_i)));

   // R9: return restores MIE from MPIE and sets MPIE
   a_r9_return_status: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && c_mret && !mstatus_q[3]) |=>
         (mstatus_q[3] == $past(mstatus_q[7]) && mstatus_q[7]));

   // R10: a trap cycle never lets an instruction write through
   a_r10_no_ins_write: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> $stable(mie_q));
endmodule

bind mtrap_ctrl mtrap_ctrl_chk #(.XLEN(XLEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_i    (instr_i),
   .jump_i     (jump_i),
   .jump_addr_i(jump_addr_i),
   .redirect_o (redirect_o),
   .mstatus_q  (mstatus_q),
   .mie_q      (mie_q),
   .mepc_q     (mepc_q)
);

// File: tb/tb_mtrap_ctrl.sv
module tb_mtrap_ctrl;
   localparam logic [31:0] NOP    = 32'h00000013;
   localparam logic [31:0] ECALL  = 32'h00000073;
   localparam logic [31:0] EBREAK = 32'h00100073;
   localparam logic [31:0] MRET   = 32'h30200073;

   function automatic logic [31:0] mk(input logic [11:0] a, input logic [2:0] f3);
      return {a, 5'd0, f3, 5'd1, 7'h73};
   endfunction

   // {instr, src, expected old value}
   localparam int NV = 13;
   localparam logic [95:0] VEC [NV] = '{
      {mk(12'h305, 3'b001), 32'h00000200, 32'h00000000},  // R2 write
      {mk(12'h305, 3'b010), 32'h00000003, 32'h00000200},  // R2 set
      {mk(12'h305, 3'b011), 32'h00000001, 32'h00000203},  // R2 clear
      {mk(12'h305, 3'b110), 32'h00000000, 32'h00000202},  // R2 imm-set read
      {mk(12'h304, 3'b001), 32'hFFFFFFFF, 32'h00000000},  // R3 mie write
      {mk(12'h304, 3'b010), 32'h00000000, 32'h00000880},  // R3 mie mask
      {mk(12'h7C0, 3'b001), 32'h00000055, 32'h00000000},  // R3 unknown
      {mk(12'h7C0, 3'b010), 32'h00000000, 32'h00000000},  // R3 unknown read
      {mk(12'h300, 3'b001), 32'hFFFFFFFF, 32'h00000000},  // R3 mstatus write
      {mk(12'h300, 3'b011), 32'hFFFFF7F7, 32'h00001888},  // R3 mstatus mask
      {mk(12'h300, 3'b010), 32'h00000000, 32'h00000808},  // R2 mstatus after clear
      {mk(12'h341, 3'b101), 32'h00001234, 32'h00000000},  // R2 mepc imm-write
      {mk(12'h341, 3'b011), 32'hFFFFFFFF, 32'h00001234}   // R2 mepc clear
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = NOP, pc = '0, jaddr = '0, src = '0;
   logic        jmp = 1'b0;
   logic [1:0]  irq = 2'b00;
   logic        redirect_o;
   logic [31:0] redirect_addr_o, csr_rdata_o;
   logic        o_rd;
   logic [31:0] o_ad, o_data, rv;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   mtrap_ctrl dut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_i(pc), .jump_i(jmp),
      .jump_addr_i(jaddr), .irq_i(irq), .csr_src_i(src),
      .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o),
      .csr_rdata_o(csr_rdata_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drv(input logic [31:0] ins, input logic [31:0] s, input logic [31:0] p,
                      input logic j, input logic [31:0] ja, input logic [1:0] q);
      @(negedge clk);
      instr = ins; src = s; pc = p; jmp = j; jaddr = ja; irq = q;
      #1;
      o_rd = redirect_o; o_ad = redirect_addr_o; o_data = csr_rdata_o;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      drv(mk(a, 3'b010), 32'h0, 32'h0, 1'b0, 32'h0, 2'b00);
      v = o_data;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      rd(12'h300, rv); chk("R1 mstatus", rv, 32'h0);
      rd(12'h304, rv); chk("R1 mie", rv, 32'h0);
      rd(12'h305, rv); chk("R1 mtvec", rv, 32'h0);
      rd(12'h341, rv); chk("R1 mepc", rv, 32'h0);
      rd(12'h342, rv); chk("R1 mcause", rv, 32'h0);

      for (int i = 0; i < NV; i++) begin
         drv(VEC[i][95:64], VEC[i][63:32], 32'h0, 1'b0, 32'h0, 2'b00);
         chk("R2/R3 vector old value", o_data, VEC[i][31:0]);
         chk("R2/R3 vector no redirect", {31'd0, o_rd}, 32'h0);
      end

      // enable globally: mstatus = 0x8
      drv(mk(12'h300, 3'b001), 32'h8, 32'h0, 1'b0, 32'h0, 2'b00);

      // R4 ecall
      drv(ECALL, 32'h0, 32'h40, 1'b0, 32'h0, 2'b00);
      chk("R4 redirect", {31'd0, o_rd}, 32'h1);
      chk("R4 handler addr", o_ad, 32'h200);
      rd(12'h342, rv); chk("R4 mcause", rv, 32'd11);
      rd(12'h341, rv); chk("R4 mepc", rv, 32'h40);
      rd(12'h300, rv); chk("R6 mstatus entry", rv, 32'h1880);

      // R7 masked while MIE=0
      drv(NOP, 32'h0, 32'h44, 1'b0, 32'h0, 2'b10);
      chk("R7 masked", {31'd0, o_rd}, 32'h0);

      // R9 mret
      drv(MRET, 32'h0, 32'h50, 1'b0, 32'h0, 2'b00);
      chk("R9 redirect", {31'd0, o_rd}, 32'h1);
      chk("R9 return addr", o_ad, 32'h40);
      rd(12'h300, rv); chk("R9 mstatus return", rv, 32'h1888);

      // R5 + R8 ebreak with jump in flight
      drv(EBREAK, 32'h0, 32'h44, 1'b1, 32'h80, 2'b00);
      chk("R5 handler addr", o_ad, 32'h200);
      rd(12'h342, rv); chk("R5 mcause", rv, 32'd3);
      rd(12'h341, rv); chk("R8 mepc jump", rv, 32'h80);
      drv(MRET, 32'h0, 32'h0, 1'b0, 32'h0, 2'b00);
      chk("R9 return to jump", o_ad, 32'h80);

      // R7 both pending -> external
      drv(NOP, 32'h0, 32'h60, 1'b0, 32'h0, 2'b11);
      chk("R7 irq redirect", {31'd0, o_rd}, 32'h1);
      rd(12'h342, rv); chk("R7 ext cause", rv, 32'h8000000B);
      rd(12'h341, rv); chk("R7 irq mepc", rv, 32'h60);
      drv(MRET, 32'h0, 32'h0, 1'b0, 32'h0, 2'b00);

      // R7 timer only
      drv(NOP, 32'h0, 32'h64, 1'b0, 32'h0, 2'b01);
      rd(12'h342, rv); chk("R7 timer cause", rv, 32'h80000007);
      drv(MRET, 32'h0, 32'h0, 1'b0, 32'h0, 2'b00);

      // R7 external disabled in mie
      drv(mk(12'h304, 3'b011), 32'h800, 32'h0, 1'b0, 32'h0, 2'b00);
      drv(NOP, 32'h0, 32'h68, 1'b0, 32'h0, 2'b10);
      chk("R7 enable bit gates", {31'd0, o_rd}, 32'h0);

      // R10 timer interrupt collides with mtvec write and mie write
      drv(mk(12'h305, 3'b001), 32'h400, 32'h6C, 1'b0, 32'h0, 2'b01);
      chk("R10 redirect addr", o_ad, 32'h200);
      rd(12'h305, rv); chk("R10 mtvec kept", rv, 32'h202);
      rd(12'h342, rv); chk("R10 cause", rv, 32'h80000007);
      drv(MRET, 32'h0, 32'h0, 1'b0, 32'h0, 2'b00);
      drv(mk(12'h304, 3'b001), 32'h0, 32'h70, 1'b0, 32'h0, 2'b01);
      rd(12'h304, rv); chk("R10 mie kept", rv, 32'h080);
      drv(MRET, 32'h0, 32'h0, 1'b0, 32'h0, 2'b00);

      // R11 interrupt beats ecall
      drv(ECALL, 32'h0, 32'h74, 1'b0, 32'h0, 2'b01);
      chk("R11 redirect", {31'd0, o_rd}, 32'h1);
      rd(12'h342, rv); chk("R11 cause", rv, 32'h80000007);
      rd(12'h300, rv); chk("R6 MPIE from MIE", rv, 32'h1880);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule